// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This block converts the level status flags of a serial interface controller into sticky interrupt causes. Each flag is sampled on every clock and compared with its previous sample. When a flag goes from 0 to 1, the cause bit at the same index is set. A flag that stays high sets nothing further, so software can clear a cause while the condition is still present and not see it return.

Software clears causes by writing ones to them. A per-bit enable register selects which causes can drive the single interrupt line, and that line is registered. Software is expected to check the live status before it relies on an interrupt, because a condition that is already high when its enable is turned on produces no interrupt.

Top module: `irq_cause_unit`

## Requirements
- R1: A cause bit is set in the clock cycle after the status bit at the same index goes from 0 to 1. Cause bit i always tracks status bit i, for example index 0 for transfer done and index 3 for write FIFO ready.
- R2: A status bit that stays high never sets its cause bit again after that cause has been cleared.
- R3: When `cause_clr_i` is high, each bit of `cause_clr_bits_i` that is 1 clears the matching cause bit and each bit that is 0 leaves it unchanged. A value of all ones clears every cause.
- R4: While `rst_ni` is low, `cause_o` and `mask_o` are all zero and `irq_o` is 0.
- R5: `irq_o` is the OR of (cause AND mask), registered, so it changes one cycle after the cause or mask register changes.
- R6: If a rising edge and a clear request hit the same bit in the same cycle, the bit ends up set.
- R7: When `mask_o` is all zero, `irq_o` stays 0 whatever the causes are. A write with `mask_wr_i` high loads `mask_wdata_i`, and `mask_o` shows the new value in the next cycle.
- R8: If a status bit is already high when its mask bit is enabled, and its cause was cleared earlier, no interrupt is raised.
- R9: A rising edge is found by comparing each sample with the sample from the previous clock. A status pulse one cycle long is therefore captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 13 | Level status flags from the controller |
| cause_clr_i | input | 1 | Strobe for a write-one-to-clear of the causes |
| cause_clr_bits_i | input | 13 | Bits to clear when `cause_clr_i` is high |
| mask_wr_i | input | 1 | Strobe to load the mask register |
| mask_wdata_i | input | 13 | New mask value |
| cause_o | output | 13 | Cause register readback |
| mask_o | output | 13 | Mask register readback |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The embedded assertions check four rules on every cycle:
- a cause bit never appears without a detected rise;
- a detected rise always sets its cause, including when a clear request hits the same bit;
- a cleared bit with no rise stays cleared;
- an all-zero mask keeps the interrupt line low, and the line only rises when an enabled cause was present the cycle before.

Some behaviours need a sequence of stimulus, so only the bench scenarios show them:
- a level held high through a clear;
- an enable turned on over a condition that is already high;
- a pulse one cycle long;
- the exact one-cycle latency of the interrupt line.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned STAT_W = 13;

  // status index map, shared by the status source and the cause register
  localparam int unsigned IDX_XFER_DONE  = 0;
  localparam int unsigned IDX_XFER_RDY   = 1;
  localparam int unsigned IDX_RX_RDY     = 2;
  localparam int unsigned IDX_TX_RDY     = 3;
  localparam int unsigned IDX_RX_EMPTY   = 4;
  localparam int unsigned IDX_TX_EMPTY   = 6;
  localparam int unsigned IDX_ADDR_UNCFG = 12;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_i;
  end

  assign rise_o = status_i & ~status_q;

  // R9: a flagged rise was low at the previous sample
  p_rise_after_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_o & $past(status_i)) == '0))
    else $error("p_rise_after_low_r9");
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_i ? clr_bits_i : '0;

  // set has priority over clear, per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cause_q[i] <= 1'b0;
      else if (rise_i[i]) cause_q[i] <= 1'b1;
      else if (clr_vec[i]) cause_q[i] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R1, R6: a rise always lands in the cause register
  p_rise_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_i) |=> ((cause_q & $past(rise_i)) == $past(rise_i)))
    else $error("p_rise_sets_r1");

  // R2: no newly set bit without a rise
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise_i)) == '0))
    else $error("p_no_spurious_r2");

  // R3: clear without a rise empties the bit
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((cause_q & $past(clr_bits_i) & ~$past(rise_i)) == '0))
    else $error("p_clear_r3");
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_wr_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [W-1:0] cause_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_wdata_i;
      irq_q <= |(cause_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R7: all-zero mask keeps the line low
  p_mask_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_q)
    else $error("p_mask_zero_r7");

  // R5: line rises only after an enabled cause was present
  p_irq_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(|(cause_i & mask_q)))
    else $error("p_irq_source_r5");
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int unsigned SRC_W = irq_cause_pkg::STAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] status_i,
  input  logic             cause_clr_i,
  input  logic [SRC_W-1:0] cause_clr_bits_i,
  input  logic             mask_wr_i,
  input  logic [SRC_W-1:0] mask_wdata_i,
  output logic [SRC_W-1:0] cause_o,
  output logic [SRC_W-1:0] mask_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] rise;
  logic [SRC_W-1:0] cause;

  irq_edge_detect #(.W(SRC_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .rise_o   (rise)
  );

  irq_cause_reg #(.W(SRC_W)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .clr_i      (cause_clr_i),
    .clr_bits_i (cause_clr_bits_i),
    .cause_o    (cause)
  );

  irq_mask_out #(.W(SRC_W)) u_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .cause_i      (cause),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
  );

  assign cause_o = cause;
endmodule

// File: tb/irq_cause_unit_test.sv
module irq_cause_unit_test;
  import irq_cause_pkg::*;
  localparam int W = STAT_W;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] status_i = '0;
  logic         cause_clr_i = 1'b0;
  logic [W-1:0] cause_clr_bits_i = '0;
  logic         mask_wr_i = 1'b0;
  logic [W-1:0] mask_wdata_i = '0;
  logic [W-1:0] cause_o, mask_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_cause_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status_i),
    .cause_clr_i(cause_clr_i), .cause_clr_bits_i(cause_clr_bits_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [W-1:0] m);
    mask_wr_i = 1'b1; mask_wdata_i = m;
    step(1);
    mask_wr_i = 1'b0;
  endtask

  task automatic clear(input logic [W-1:0] b);
    cause_clr_i = 1'b1; cause_clr_bits_i = b;
    step(1);
    cause_clr_i = 1'b0; cause_clr_bits_i = '0;
  endtask

  task automatic t_reset;
    status_i = '1;
    step(2);
    chk("R4 cause", cause_o, '0);
    chk("R4 mask", mask_o, '0);
    chk("R4 irq", W'(irq_o), '0);
    status_i = '0;
    step(1);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_rise_and_latency;
    write_mask('1);
    chk("R7 mask readback", mask_o, '1);
    status_i[IDX_TX_RDY] = 1'b1;
    step(1);
    chk("R1 tx ready position", cause_o, W'(1) << IDX_TX_RDY);
    chk("R5 irq not yet", W'(irq_o), '0);
    step(1);
    chk("R5 irq one cycle later", W'(irq_o), W'(1));
  endtask

  task automatic t_held_high;
    clear(W'(1) << IDX_TX_RDY);
    chk("R3 clear bit", cause_o, '0);
    step(3);
    chk("R2 held high no reset", cause_o, '0);
    chk("R5 irq drops", W'(irq_o), '0);
    status_i = '0;
    step(1);
  endtask

  task automatic t_partial_and_all_clear;
    status_i[IDX_XFER_DONE] = 1'b1;
    status_i[IDX_ADDR_UNCFG] = 1'b1;
    status_i[IDX_RX_EMPTY] = 1'b1;
    step(1);
    chk("R1 multi positions", cause_o,
        (W'(1) << IDX_XFER_DONE) | (W'(1) << IDX_ADDR_UNCFG) | (W'(1) << IDX_RX_EMPTY));
    clear(W'(1) << IDX_RX_EMPTY);
    chk("R3 zeros keep", cause_o, (W'(1) << IDX_XFER_DONE) | (W'(1) << IDX_ADDR_UNCFG));
    clear('1);
    chk("R3 all ones", cause_o, '0);
    status_i = '0;
    step(1);
  endtask

  task automatic t_collision;
    status_i[IDX_XFER_RDY] = 1'b1;
    status_i[IDX_TX_EMPTY] = 1'b1;
    step(1);
    status_i = '0;
    step(1);
    status_i[IDX_XFER_RDY] = 1'b1;
    cause_clr_i = 1'b1;
    cause_clr_bits_i = (W'(1) << IDX_XFER_RDY) | (W'(1) << IDX_TX_EMPTY);
    step(1);
    cause_clr_i = 1'b0; cause_clr_bits_i = '0;
    chk("R6 set wins", cause_o, W'(1) << IDX_XFER_RDY);
    status_i = '0;
    clear('1);
  endtask

  task automatic t_mask_block;
    write_mask('0);
    status_i = '1;
    step(1);
    chk("R7 causes latched", cause_o, '1);
    step(3);
    chk("R7 irq blocked", W'(irq_o), '0);
    write_mask(W'(1) << IDX_RX_RDY);
    chk("R7 mask loaded", mask_o, W'(1) << IDX_RX_RDY);
    step(1);
    chk("R5 irq after unmask", W'(irq_o), W'(1));
    clear('1);
    step(1);
    chk("R5 irq clears", W'(irq_o), '0);
  endtask

  task automatic t_already_high;
    write_mask('0);
    step(1);
    write_mask(W'(1) << IDX_RX_RDY);
    step(3);
    chk("R8 no cause", cause_o, '0);
    chk("R8 no irq", W'(irq_o), '0);
    status_i = '0;
    step(1);
  endtask

  task automatic t_pulse;
    write_mask('1);
    status_i[IDX_RX_RDY] = 1'b1;
    step(1);
    status_i = '0;
    step(2);
    chk("R9 pulse captured", cause_o, W'(1) << IDX_RX_RDY);
    chk("R9 pulse irq", W'(irq_o), W'(1));
    clear('1);
  endtask

  initial begin
    fork
      begin
        step(1);
        t_reset();
        t_rise_and_latency();
        t_held_high();
        t_partial_and_all_clear();
        t_collision();
        t_mask_block();
        status_i = '1;
        step(1);
        clear('1);
        t_already_high();
        t_pulse();
      end
      begin
        step(5000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule